// File: doc/BRIEF.md
# Whole-Cache Invalidate Sequencer

This block clears the valid bits of a set-associative cache on command. Software writes a control word; when the invalidate-all bit in that word is 1, the block steps through every set from index 0 upward and clears all ways of one set on each clock, through the write port of the valid-bit array. While the sweep runs, it holds off local bus accesses with a stall output. After the last set it lowers the invalidate bit by itself and pulses a done output.

The block also serves a single-line push command. A keep-on-push bit, loaded with every control write, decides whether the pushed line is invalidated or left valid. Pushes are accepted only while no sweep is running. Reset clears the block's own state but never writes the valid array, so cache contents survive reset until an explicit invalidate. Dirty-line write-back is handled elsewhere.

Top module: `cache_inval_seq`

## Requirements
- R1: A control write (ctrl_we_i=1) with ctrl_inv_i=1 while idle raises busy_o in the next cycle.
- R2: A control write with ctrl_inv_i=0 starts nothing: busy_o stays low and vld_we_o stays low.
- R3: During a sweep, every cycle writes one set with vld_we_o=1 and vld_way_mask_o all ones, and vld_set_o counts 0, 1, 2 ... NUM_SETS-1 in order, so every line is cleared once.
- R4: busy_o is high for exactly NUM_SETS consecutive cycles per sweep; stall_o equals bus_req_i while busy_o is high and is 0 otherwise.
- R5: inv_pending_o is 1 from the cycle after the starting write to the last sweep cycle and returns to 0 with no further write; done_o is high for the single cycle after the last set.
- R6: Reset writes nothing to the valid array: after reset vld_we_o stays low, busy_o, inv_pending_o and keep_on_push_o are 0.
- R7: A push (push_req_i=1) while idle with keep_on_push_o=0 drives, in the same cycle, push_ack_o=1, vld_we_o=1, vld_set_o=push_set_i and vld_way_mask_o with only bit push_way_i set (bit i is way i).
- R8: A push while idle with keep_on_push_o=1 gives push_ack_o=1 and vld_we_o=0, leaving the line valid.
- R9: A push during a sweep is not accepted: push_ack_o stays 0 and the port keeps serving the sweep.
- R10: A second control write with ctrl_inv_i=1 during a sweep does not restart it: the set index keeps counting and busy_o still lasts NUM_SETS cycles.
- R11: keep_on_push_o takes ctrl_keep_i on every control write and holds it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_inv_i | input | 1 | Invalidate-all bit of the written word |
| ctrl_keep_i | input | 1 | Keep-on-push bit of the written word |
| inv_pending_o | output | 1 | Invalidate-all bit readback, self-clearing |
| keep_on_push_o | output | 1 | Keep-on-push bit readback |
| bus_req_i | input | 1 | Local bus access request |
| stall_o | output | 1 | Bus access held off |
| push_req_i | input | 1 | Line push command |
| push_set_i | input | SET_W (7) | Set of the pushed line |
| push_way_i | input | WAY_W (2) | Way of the pushed line |
| push_ack_o | output | 1 | Push accepted this cycle |
| vld_we_o | output | 1 | Valid array clear strobe |
| vld_set_o | output | SET_W (7) | Set being cleared |
| vld_way_mask_o | output | NUM_WAYS (4) | Ways being cleared |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle pulse after the sweep ends |

## Verification
The sweep is tried with the bus requesting throughout, with a repeated start write in mid-sweep, and with a push arriving mid-sweep; comparing a bench-side copy of the valid array and the observed set order tells a skipped, repeated or restarted set apart from a correct walk. Pushes are tried with the keep bit at 0 and at 1 on chosen sets and ways, which separates a wrong way decode from a push that ignores the keep bit. A zero write and a bare reset check that nothing touches the array without a command.

// File: rtl/cinv_pkg.sv
package cinv_pkg;
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sweep_state_e;
endpackage

// File: rtl/cinv_ctrl_reg.sv
module cinv_ctrl_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic inv_bit_i,
  input  logic keep_bit_i,
  input  logic sweep_end_i,
  output logic inv_q_o,
  output logic keep_q_o
);
  logic inv_q, keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q  <= 1'b0;
      keep_q <= 1'b0;
    end else begin
      if (we_i) keep_q <= keep_bit_i;
      // end of sweep wins over a late rewrite
      if (sweep_end_i)            inv_q <= 1'b0;
      else if (we_i && inv_bit_i) inv_q <= 1'b1;
    end
  end

  assign inv_q_o  = inv_q;
  assign keep_q_o = keep_q;

  a_r11_keep_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (keep_q == $past(keep_bit_i)));
endmodule

// File: rtl/cinv_sweep.sv
module cinv_sweep
  import cinv_pkg::*;
#(
  parameter int NUM_SETS = 128,
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic             end_o,
  output logic             done_o,
  output logic [SET_W-1:0] idx_o
);
  localparam logic [SET_W-1:0] LAST_IDX = SET_W'(NUM_SETS - 1);

  sweep_state_e     state_q;
  logic [SET_W-1:0] idx_q;
  logic             done_q;
  logic             at_end;

  assign at_end = (state_q == SW_RUN) && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= at_end;
      unique case (state_q)
        SW_IDLE: if (start_i) begin
          state_q <= SW_RUN;
          idx_q   <= '0;
        end
        SW_RUN: begin
          if (at_end) begin
            state_q <= SW_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == SW_RUN);
  assign end_o  = at_end;
  assign done_o = done_q;
  assign idx_o  = idx_q;

  a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (idx_q == $past(idx_q) + 1'b1));
  a_r10_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (idx_q != '0));
  a_r5_done_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r1_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && idx_q == '0));
endmodule

// File: rtl/cinv_port_mux.sv
module cinv_port_mux #(
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 7,
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                busy_i,
  input  logic [SET_W-1:0]    idx_i,
  input  logic                push_req_i,
  input  logic [SET_W-1:0]    push_set_i,
  input  logic [WAY_W-1:0]    push_way_i,
  input  logic                keep_i,
  output logic                push_ack_o,
  output logic                we_o,
  output logic [SET_W-1:0]    set_o,
  output logic [NUM_WAYS-1:0] mask_o
);
  logic [NUM_WAYS-1:0] way_dec;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way_dec
    assign way_dec[w] = (push_way_i == WAY_W'(w));
  end

  always_comb begin
    push_ack_o = push_req_i && !busy_i;
    we_o       = 1'b0;
    set_o      = push_set_i;
    mask_o     = '0;
    if (busy_i) begin
      we_o   = 1'b1;
      set_o  = idx_i;
      mask_o = '1;
    end else if (push_ack_o && !keep_i) begin
      we_o   = 1'b1;
      mask_o = way_dec;
    end
  end

  a_r9_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !push_ack_o);
  a_r7_push_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !busy_i) |-> ($onehot0(mask_o) && $countones(mask_o) == 1));
  a_r8_keep_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_ack_o && keep_i) |-> !we_o);
endmodule

// File: rtl/cache_inval_seq.sv
module cache_inval_seq #(
  parameter int NUM_SETS = 128,
  parameter int NUM_WAYS = 4,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic                ctrl_inv_i,
  input  logic                ctrl_keep_i,
  output logic                inv_pending_o,
  output logic                keep_on_push_o,
  input  logic                bus_req_i,
  output logic                stall_o,
  input  logic                push_req_i,
  input  logic [SET_W-1:0]    push_set_i,
  input  logic [WAY_W-1:0]    push_way_i,
  output logic                push_ack_o,
  output logic                vld_we_o,
  output logic [SET_W-1:0]    vld_set_o,
  output logic [NUM_WAYS-1:0] vld_way_mask_o,
  output logic                busy_o,
  output logic                done_o
);
  logic             busy, sweep_end, start;
  logic [SET_W-1:0] idx;

  assign start = ctrl_we_i && ctrl_inv_i && !busy;

  cinv_ctrl_reg u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctrl_we_i),
    .inv_bit_i   (ctrl_inv_i),
    .keep_bit_i  (ctrl_keep_i),
    .sweep_end_i (sweep_end),
    .inv_q_o     (inv_pending_o),
    .keep_q_o    (keep_on_push_o)
  );

  cinv_sweep #(.NUM_SETS(NUM_SETS)) u_sweep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .busy_o  (busy),
    .end_o   (sweep_end),
    .done_o  (done_o),
    .idx_o   (idx)
  );

  cinv_port_mux #(.NUM_WAYS(NUM_WAYS), .SET_W(SET_W)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .busy_i     (busy),
    .idx_i      (idx),
    .push_req_i (push_req_i),
    .push_set_i (push_set_i),
    .push_way_i (push_way_i),
    .keep_i     (keep_on_push_o),
    .push_ack_o (push_ack_o),
    .we_o       (vld_we_o),
    .set_o      (vld_set_o),
    .mask_o     (vld_way_mask_o)
  );

  assign busy_o  = busy;
  assign stall_o = bus_req_i && busy;

  a_r4_stall_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> busy_o);
  a_r6_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !push_req_i) |-> !vld_we_o);
  a_r5_pending_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> inv_pending_o);
endmodule

// File: tb/cache_inval_seq_test.sv
module cache_inval_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 128;
  localparam int NWAYS = 4;

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0, ctrl_inv = 0, ctrl_keep = 0;
  logic bus_req = 0, push_req = 0;
  logic [6:0] push_set = '0;
  logic [1:0] push_way = '0;
  logic inv_pending, keep_on_push, stall, push_ack, vld_we, busy, done;
  logic [6:0] vld_set;
  logic [3:0] vld_mask;

  int n_tests = 0, n_fail = 0;
  int seq_err = 0;
  int sweep_next = 0;
  logic [NWAYS-1:0] vmodel [NSETS];

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_inval_seq uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_inv_i(ctrl_inv), .ctrl_keep_i(ctrl_keep),
    .inv_pending_o(inv_pending), .keep_on_push_o(keep_on_push),
    .bus_req_i(bus_req), .stall_o(stall),
    .push_req_i(push_req), .push_set_i(push_set), .push_way_i(push_way),
    .push_ack_o(push_ack), .vld_we_o(vld_we), .vld_set_o(vld_set),
    .vld_way_mask_o(vld_mask), .busy_o(busy), .done_o(done)
  );

  // bench copy of the valid array, plus sweep order tracking
  always @(posedge clk) begin
    if (vld_we) begin
      vmodel[vld_set] <= vmodel[vld_set] & ~vld_mask;
      if (vld_mask == 4'hF) begin
        if (int'(vld_set) != sweep_next) seq_err++;
        sweep_next = (int'(vld_set) == NSETS-1) ? 0 : int'(vld_set) + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_model();
    for (int s = 0; s < NSETS; s++) vmodel[s] = '1;
  endtask

  function automatic int count_valid();
    int c = 0;
    for (int s = 0; s < NSETS; s++) c += $countones(vmodel[s]);
    return c;
  endfunction

  task automatic ctrl_write(input logic inv, input logic keep);
    @(negedge clk);
    ctrl_we = 1; ctrl_inv = inv; ctrl_keep = keep;
    @(negedge clk);
    ctrl_we = 0; ctrl_inv = 0;
  endtask

  task automatic t_reset();
    int writes = 0;
    fill_model();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (vld_we) writes++;
    end
    check(writes == 0, "R6 no write after reset", writes, 0);
    check(!busy && !inv_pending && !keep_on_push, "R6 reset state",
          {busy, inv_pending, keep_on_push}, 0);
    check(count_valid() == NSETS*NWAYS, "R6 valid kept", count_valid(), NSETS*NWAYS);
  endtask

  task automatic t_zero_write();
    int writes = 0;
    ctrl_write(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      if (vld_we || busy) writes++;
      @(negedge clk);
    end
    check(writes == 0, "R2 zero write ignored", writes, 0);
    check(count_valid() == NSETS*NWAYS, "R2 array untouched", count_valid(), NSETS*NWAYS);
  endtask

  task automatic t_push_inv();
    @(negedge clk);
    push_req = 1; push_set = 7'd5; push_way = 2'd2;
    #1;
    check(push_ack && vld_we, "R7 push accepted and writes", {push_ack, vld_we}, 3);
    check(vld_set == 7'd5 && vld_mask == 4'b0100, "R7 push set/mask",
          {vld_set, vld_mask}, {7'd5, 4'b0100});
    @(negedge clk);
    push_req = 0;
    check(vmodel[5] == 4'b1011, "R7 line cleared", vmodel[5], 4'b1011);
  endtask

  task automatic t_push_keep();
    ctrl_write(1'b0, 1'b1);
    check(keep_on_push == 1'b1, "R11 keep bit loaded", keep_on_push, 1);
    push_req = 1; push_set = 7'd6; push_way = 2'd1;
    #1;
    check(push_ack && !vld_we, "R8 push without write", {push_ack, vld_we}, 2);
    @(negedge clk);
    push_req = 0;
    check(vmodel[6] == 4'hF, "R8 line stays valid", vmodel[6], 15);
    ctrl_write(1'b0, 1'b0);
    check(keep_on_push == 1'b0, "R11 keep bit cleared", keep_on_push, 0);
  endtask

  task automatic t_full_sweep();
    int cyc = 0, stall_bad = 0, pend_bad = 0, pend_seen;
    fill_model();
    seq_err = 0; sweep_next = 0;
    bus_req = 1;
    ctrl_write(1'b1, 1'b0);
    check(busy == 1'b1, "R1 busy next cycle", busy, 1);
    while (busy && cyc < 1000) begin
      cyc++;
      if (stall != 1'b1) stall_bad++;
      if (inv_pending != 1'b1) pend_bad++;
      @(negedge clk);
    end
    check(cyc == NSETS, "R4 busy length", cyc, NSETS);
    check(stall_bad == 0, "R4 stall while busy", stall_bad, 0);
    check(pend_bad == 0, "R5 pending during sweep", pend_bad, 0);
    check(stall == 1'b0, "R4 stall released", stall, 0);
    check(done == 1'b1, "R5 done pulse", done, 1);
    pend_seen = inv_pending;
    check(pend_seen == 0, "R5 bit self-clears", pend_seen, 0);
    check(count_valid() == 0, "R3 all lines cleared", count_valid(), 0);
    check(seq_err == 0, "R3 ascending order", seq_err, 0);
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", done, 0);
    bus_req = 0;
  endtask

  task automatic t_rewrite_and_push();
    int cyc = 0, ack_bad = 0;
    fill_model();
    seq_err = 0; sweep_next = 0;
    ctrl_write(1'b1, 1'b0);
    while (busy && cyc < 1000) begin
      cyc++;
      if (cyc == 40) begin
        ctrl_we = 1; ctrl_inv = 1;
      end else begin
        ctrl_we = 0; ctrl_inv = 0;
      end
      push_req = (cyc == 60);
      push_set = 7'd3; push_way = 2'd0;
      #1;
      if (push_ack) ack_bad++;
      @(negedge clk);
    end
    ctrl_we = 0; ctrl_inv = 0; push_req = 0;
    check(cyc == NSETS, "R10 no restart length", cyc, NSETS);
    check(seq_err == 0, "R10 order unbroken", seq_err, 0);
    check(ack_bad == 0, "R9 no ack during sweep", ack_bad, 0);
    check(count_valid() == 0, "R9 sweep still complete", count_valid(), 0);
  endtask

  initial begin : main
    t_reset();
    t_zero_write();
    t_push_inv();
    t_push_keep();
    t_full_sweep();
    t_rewrite_and_push();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule